// File: doc/BRIEF.md
# Burst Data Beat Sequencer

This block steps through the beats of one data tenure on a 64-bit data path. A tenure is either one beat or a four-beat burst that fills a 32-byte line. When a tenure starts, the block picks the double-word index of the first beat. After that it advances the index once for every beat the slave acknowledges. It also reverses the most recent read beat when the slave reports, one clock late, that the read data was bad.

The surrounding bus master pulses `start_i` while the sequencer is idle. With the pulse it gives the tenure shape: a burst flag, a critical-word-first flag, a write flag and the requested double word. While the tenure runs, `beat_idx_o` selects the double word for the current beat. `dvalid_o` marks each accepted beat. `done_o` pulses once the tenure can no longer be retried.

Top module: `burst_beat_seq`

## Requirements
- R1: A burst started with the critical-first flag set (a cacheable miss fill) presents the requested double word `start_dw_i` as its first beat, for both reads and writes.
- R2: A burst started with the critical-first flag clear presents double word 0 as its first beat, whatever `start_dw_i` holds.
- R3: Each accepted burst beat moves `beat_idx_o` up by one modulo 4, so the index wraps inside the line (for example 2, 3, 0, 1).
- R4: A single-beat tenure (burst flag clear) uses `start_dw_i` and completes after exactly one accepted beat. `burst_o` is 1 for a four-beat tenure and 0 for a single-beat tenure while the tenure is in progress.
- R5: A beat is accepted only in a cycle where `ta_i` is high. `dvalid_o` is high in exactly those cycles. While `ta_i` is withheld, `beat_idx_o` holds for any number of clocks.
- R6: In a read tenure, `drtry_i` high in the clock right after an accepted beat cancels that beat. `beat_idx_o` returns to that beat's index, the beat is not counted, and a `ta_i` in the retry clock is not accepted. `drtry_i` with no beat accepted in the previous clock has no effect.
- R7: In a write tenure, `drtry_i` is ignored. Beats, index steps and `done_o` behave as if it were low.
- R8: `done_o` pulses for one clock, in the clock after the final beat is accepted, unless a read retry arrives in that clock. In that case the final beat is run again and `done_o` follows its next acceptance.
- R9: During and right after reset the sequencer is idle: `beat_idx_o`, `dvalid_o`, `burst_o` and `done_o` are all 0.
- R10: `start_i` is ignored while a tenure is in progress. The index and burst indicator keep following the running tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a tenure (taken only when idle) |
| burst_i | input | 1 | 1: four-beat burst, 0: single beat |
| crit_first_i | input | 1 | 1: burst begins at the requested double word |
| write_i | input | 1 | 1: write tenure, 0: read tenure |
| start_dw_i | input | 2 | Requested double word within the line |
| ta_i | input | 1 | Slave transfer acknowledge for the current beat |
| drtry_i | input | 1 | Previous clock's read data invalid |
| beat_idx_o | output | 2 | Double-word index of the current beat |
| dvalid_o | output | 1 | High in a clock where a beat is accepted |
| burst_o | output | 1 | High while a four-beat tenure is in progress |
| done_o | output | 1 | One-clock pulse when the tenure has finished |

## Verification
An index pointer that drifts from the beat tally shows up first at `beat_idx_o`. That happens in the cycle after the faulty acceptance or retry, well before `done_o` would betray a wrong count. A tally that miscounts shows up as `done_o` arriving one or more acknowledged beats early or late. A retry that is applied in the wrong tenure type, or in the wrong clock, shows up within two clocks: either an accepted `dvalid_o` that should have been blocked, or an index that fails to step back. The bench therefore compares the index on every beat against its own calculation, and places `done_o` on an exact clock.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  // Double-word index width; a line holds 2**IDX_W beats.
  localparam int unsigned IDX_W = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_XFER = 2'd1,
    SEQ_CHK  = 2'd2
  } seq_state_e;

  // First beat: line-aligned unless critical-first or single beat.
  function automatic logic [IDX_W-1:0] first_dw(input logic burst,
                                                input logic crit,
                                                input logic [IDX_W-1:0] req);
    return (burst && !crit) ? '0 : req;
  endfunction

  // Step one beat forward or back, wrapping within the line.
  function automatic logic [IDX_W-1:0] wrap_step(input logic [IDX_W-1:0] idx,
                                                 input logic up);
    return up ? idx + 1'b1 : idx - 1'b1;
  endfunction
endpackage

// File: rtl/bbs_dw_pointer.sv
module bbs_dw_pointer #(
  parameter int unsigned IDX_W = bbs_pkg::IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_val,
  input  logic             adv,
  input  logic             back,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (load) idx_q <= load_val;
    else if (back) idx_q <= bbs_pkg::wrap_step(idx_q, 1'b0);
    else if (adv)  idx_q <= bbs_pkg::wrap_step(idx_q, 1'b1);
  end

  assign idx = idx_q;
endmodule

// File: rtl/bbs_beat_tally.sv
module bbs_beat_tally #(
  parameter int unsigned IDX_W = bbs_pkg::IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic             dec,
  input  logic             is_burst,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_BURST = {IDX_W{1'b1}};

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (dec)   cnt_q <= cnt_q - 1'b1;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == (is_burst ? LAST_BURST : '0));
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq #(
  parameter int unsigned IDX_W = bbs_pkg::IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             burst_i,
  input  logic             crit_first_i,
  input  logic             write_i,
  input  logic [IDX_W-1:0] start_dw_i,
  input  logic             ta_i,
  input  logic             drtry_i,
  output logic [IDX_W-1:0] beat_idx_o,
  output logic             dvalid_o,
  output logic             burst_o,
  output logic             done_o
);
  import bbs_pkg::*;

  seq_state_e state_q, state_d;
  logic       burst_q, wr_q, acc_q;

  // Named internal events
  logic busy, in_xfer, in_chk;
  logic tenure_go, retry_hit, beat_ack, last_beat;

  assign in_xfer   = (state_q == SEQ_XFER);
  assign in_chk    = (state_q == SEQ_CHK);
  assign busy      = in_xfer || in_chk;
  assign tenure_go = (state_q == SEQ_IDLE) && start_i;
  assign retry_hit = busy && acc_q && !wr_q && drtry_i;
  assign beat_ack  = in_xfer && ta_i && !retry_hit;

  bbs_dw_pointer #(.IDX_W(IDX_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tenure_go),
    .load_val (first_dw(burst_i, crit_first_i, start_dw_i)),
    .adv      (beat_ack),
    .back     (retry_hit),
    .idx      (beat_idx_o)
  );

  bbs_beat_tally #(.IDX_W(IDX_W)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tenure_go),
    .inc      (beat_ack),
    .dec      (retry_hit),
    .is_burst (burst_q),
    .last     (last_beat)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (start_i) state_d = SEQ_XFER;
      SEQ_XFER: if (beat_ack && last_beat) state_d = SEQ_CHK;
      SEQ_CHK:  state_d = retry_hit ? SEQ_XFER : SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      burst_q <= 1'b0;
      wr_q    <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      acc_q   <= beat_ack;
      if (tenure_go) begin
        burst_q <= burst_i;
        wr_q    <= write_i;
      end
    end
  end

  assign dvalid_o = beat_ack;
  assign burst_o  = burst_q && busy;
  assign done_o   = in_chk && !retry_hit;
endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
  parameter int unsigned IDX_W = bbs_pkg::IDX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             ta_i,
  input logic             drtry_i,
  input logic [IDX_W-1:0] beat_idx_o,
  input logic             dvalid_o,
  input logic             burst_o,
  input logic             done_o,
  input logic             in_xfer,
  input logic             in_chk,
  input logic             wr_q
);
  // R5
  ack_needs_ta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid_o |-> ta_i);

  // R3
  idx_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && $past(dvalid_o)) |-> (beat_idx_o == IDX_W'($past(beat_idx_o) + 1'b1)));

  // R6
  read_retry_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dvalid_o) && drtry_i && !wr_q) |-> (!dvalid_o && !done_o));

  // R7
  write_retry_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_chk && wr_q) |-> done_o);

  // R8
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(dvalid_o));

  // R10
  start_ignored_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && start_i) |=> $stable(burst_o));
endmodule

bind burst_beat_seq bbs_checker #(.IDX_W(IDX_W)) u_bbs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .ta_i       (ta_i),
  .drtry_i    (drtry_i),
  .beat_idx_o (beat_idx_o),
  .dvalid_o   (dvalid_o),
  .burst_o    (burst_o),
  .done_o     (done_o),
  .in_xfer    (in_xfer),
  .in_chk     (in_chk),
  .wr_q       (wr_q)
);

// File: tb/burst_beat_seq_bench.sv
`timescale 1ns/1ps
module burst_beat_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 0, burst_i = 0, crit_first_i = 0, write_i = 0;
  logic [1:0] start_dw_i = '0;
  logic       ta_i = 0, drtry_i = 0;
  logic [1:0] beat_idx_o;
  logic       dvalid_o, burst_o, done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // sampled outputs
  int s_idx, s_dv, s_burst, s_done;

  always #10 clk = ~clk;

  burst_beat_seq u_burst_beat_seq (
    .clk, .rst_n, .start_i, .burst_i, .crit_first_i, .write_i,
    .start_dw_i, .ta_i, .drtry_i, .beat_idx_o, .dvalid_o, .burst_o, .done_o
  );

  // {burst, crit, write, dw[1:0], gap[1:0]}
  localparam logic [6:0] VEC [6] = '{
    7'b1_1_0_10_00,
    7'b1_1_1_11_01,
    7'b1_0_0_11_00,
    7'b1_0_1_01_10,
    7'b0_0_0_10_01,
    7'b0_1_1_01_00
  };

  // Expected index of beat n, derived from R1..R4
  function automatic int want_idx(bit b, bit c, int dw, int n);
    int base;
    if (!b) return dw;
    base = c ? dw : 0;
    return (base + n) % 4;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit st, bit b, bit c, bit w, int dw, bit ta, bit dr);
    @(negedge clk);
    start_i = st; burst_i = b; crit_first_i = c; write_i = w;
    start_dw_i = 2'(dw); ta_i = ta; drtry_i = dr;
    #1;
    s_idx = beat_idx_o; s_dv = dvalid_o; s_burst = burst_o; s_done = done_o;
  endtask

  task automatic ack_expect(string req, int idx);
    step(0, 0, 0, 0, 0, 1, 0);
    check({req, " dvalid"}, s_dv, 1);
    check({req, " idx"}, s_idx, idx);
  endtask

  task automatic done_expect(string req);
    step(0, 0, 0, 0, 0, 0, 0);
    check({req, " done"}, s_done, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    check({req, " idle"}, s_done + s_burst, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    step(0, 0, 0, 0, 0, 0, 0);
    check("R9 idx", s_idx, 0);
    check("R9 dvalid/done/burst", s_dv + s_done + s_burst, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 1, 1);
    check("R9 after reset", s_idx + s_dv + s_done + s_burst, 0);

    // Table walk: R1 R2 R3 R4 R5 R8
    foreach (VEC[v]) begin
      bit b, c, w; int dw, gap, nb;
      {b, c, w} = VEC[v][6:4]; dw = VEC[v][3:2]; gap = VEC[v][1:0];
      nb = b ? 4 : 1;
      step(1, b, c, w, dw, 0, 0);
      for (int n = 0; n < nb; n++) begin
        for (int g = 0; g < gap; g++) begin
          step(0, 0, 0, 0, 0, 0, 0);
          check("R5 withheld dvalid", s_dv, 0);
          check("R5 withheld idx", s_idx, want_idx(b, c, dw, n));
        end
        step(0, 0, 0, 0, 0, 1, 0);
        check("R5 dvalid on ta", s_dv, 1);
        check(n == 0 ? (b ? (c ? "R1 first idx" : "R2 first idx") : "R4 single idx")
                     : "R3 wrap idx", s_idx, want_idx(b, c, dw, n));
        check("R4 burst_o", s_burst, b);
      end
      done_expect("R8 table");
    end

    // R10: start ignored while busy
    step(1, 1, 1, 0, 1, 0, 0);
    step(1, 0, 0, 1, 3, 0, 0);
    check("R10 idx held", s_idx, 1);
    check("R10 burst held", s_burst, 1);
    ack_expect("R10", 1); ack_expect("R10", 2); ack_expect("R10", 3); ack_expect("R10", 0);
    done_expect("R10");

    // R6: retry mid read burst
    step(1, 1, 1, 0, 0, 0, 0);
    ack_expect("R6 beat0", 0);
    step(0, 0, 0, 0, 0, 1, 1);
    check("R6 ta in retry clock", s_dv, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R6 idx rolled back", s_idx, 0);
    ack_expect("R6", 0); ack_expect("R6", 1); ack_expect("R6", 2); ack_expect("R6", 3);
    done_expect("R6 count kept");

    // R6: retry with no prior acceptance has no effect
    step(1, 1, 1, 0, 2, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R6 stray retry idx", s_idx, 2);
    ack_expect("R6", 2); ack_expect("R6", 3); ack_expect("R6", 0); ack_expect("R6", 1);
    done_expect("R6 stray");

    // R8: retry after last read beat
    step(1, 0, 0, 0, 1, 0, 0);
    ack_expect("R8 single", 1);
    step(0, 0, 0, 0, 0, 0, 1);
    check("R8 done blocked", s_done, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    check("R8 rerun idx", s_idx, 1);
    check("R8 no done while rerun", s_done, 0);
    ack_expect("R8 rerun", 1);
    done_expect("R8 after rerun");

    // R7: retry ignored in write burst
    step(1, 1, 0, 1, 3, 0, 0);
    ack_expect("R7", 0);
    step(0, 0, 0, 0, 0, 1, 1);
    check("R7 ack accepted", s_dv, 1);
    check("R7 idx advanced", s_idx, 1);
    ack_expect("R7", 2); ack_expect("R7", 3);
    step(0, 0, 0, 0, 0, 0, 1);
    check("R7 done despite retry", s_done, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule